// File: doc/BRIEF.md
# Bus-Programmed Countdown Event Timer

This block is a single-channel countdown timer that sits on a simple 32-bit register bus. It serves as an always-on event source that can wake processors that have stopped their local timers. Software stores a reload value in two 32-bit words and picks a counter width of 32 or 64 bits. It then chooses between free-running periodic operation and single-shot operation and starts the counter. Each time the count runs out, a sticky status flag is set. That flag, gated by an enable bit, drives one interrupt line until software acknowledges it with a write-one clear.

The count can be read live at any time. Reading the low live word also copies the whole 64-bit count into a pair of snapshot words. A later read of a snapshot half therefore belongs to the same instant as the low word that was read. Bus writes take effect on the rising clock edge at which `bus_wr` is high. Reads are combinational on `bus_rdata` while `bus_rd` is high.

Top module: `evt_timer`

## Requirements
- R1: After reset every register, the count, the snapshot and the sticky status read as zero, and `irq` is low.
- R2: Byte offsets: reload low 0x00, reload high 0x04, live count low 0x08, live count high 0x0C, control 0x10, interrupt 0x14, snapshot low 0x18, snapshot high 0x1C. The reload words read back what was written.
- R3: A control write with bit 1 (run) set loads the counter from the reload value on the following clock. While running, the counter then drops by one on every clock.
- R4: When the run bit is written as 0, the counter stops and holds its value. A later start counts from the current reload value.
- R5: While running, a clock on which the count is zero is an expiry, and it sets the sticky status on that edge. With control bit 0 set (periodic), the same edge reloads the counter, so a reload value L expires every L+1 clocks.
- R6: With control bit 0 clear (single-shot), the counter stays at zero after the first expiry and produces no further expiry until control is written again.
- R7: When control bit 16 (wide) is set, the counter is 64 bits with borrow across the halves. When it is clear, only the low 32 bits count, the reload high word has no effect and live count high reads 0.
- R8: In the interrupt register, bit 0 is a read/write enable and bit 1 is the sticky status. Bit 2 reads as status AND enable, and bit 3 always reads 0.
- R9: Writing 1 to interrupt bit 3 clears the sticky status. An expiry on the same edge keeps it set.
- R10: `irq` equals the masked status bit. Once high, it stays high until the interrupt register is written.
- R11: A read of live count low copies the full 64-bit count into the snapshot words, which return that copy until the next such read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Interrupt, high while status and enable are both set |

## Verification
The hardest case to reach is a status clear written on exactly the edge where a periodic expiry happens. The bench reaches it by counting clocks from the start write: with a reload of 3, the first expiry lands on the fifth edge after the start, and the clear write is placed on that same edge. The clear is then repeated one edge later, and the next period is awaited, so that a clear that simply does nothing is also caught. A second hard case is the borrow across the two halves of a wide count. The bench sets it up with a reload value just above 2^32 and walks the count past the boundary, reading the snapshot words in between.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   // register byte offsets
   localparam int unsigned OFF_LOAD_LO = 32'h00;
   localparam int unsigned OFF_LOAD_HI = 32'h04;
   localparam int unsigned OFF_VAL_LO  = 32'h08;
   localparam int unsigned OFF_VAL_HI  = 32'h0C;
   localparam int unsigned OFF_CTRL    = 32'h10;
   localparam int unsigned OFF_INT     = 32'h14;
   localparam int unsigned OFF_SHD_LO  = 32'h18;
   localparam int unsigned OFF_SHD_HI  = 32'h1C;
   localparam int unsigned WORD_BYTES  = 4;

   // control bit positions
   localparam int unsigned BIT_PERIODIC = 0;
   localparam int unsigned BIT_RUN      = 1;
   localparam int unsigned BIT_WIDE     = 16;

   // interrupt register bit positions
   localparam int unsigned BIT_IEN = 0;
   localparam int unsigned BIT_RAW = 1;
   localparam int unsigned BIT_MSK = 2;
   localparam int unsigned BIT_CLR = 3;

   typedef struct packed {
      logic wide;
      logic run;
      logic periodic;
   } ctrl_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned NWORDS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [NWORDS*DATA_W-1:0] load_val,
   output ctrl_t                    ctrl,
   output logic                     int_en,
   output logic                     start,
   output logic                     ctrl_wr,
   output logic                     int_wr,
   output logic                     int_clr
);
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign int_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_INT));
   assign int_clr = int_wr && bus_wdata[BIT_CLR];

   // one storage word per reload half
   for (genvar w = 0; w < NWORDS; w++) begin : g_load
      logic              hit;
      logic [DATA_W-1:0] word_q;
      assign hit = bus_wr && (bus_addr == ADDR_W'(OFF_LOAD_LO + w * WORD_BYTES));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q <= '0;
         else if (hit) word_q <= bus_wdata;
      end
      assign load_val[w*DATA_W +: DATA_W] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         int_en <= 1'b0;
         start  <= 1'b0;
      end else begin
         start <= ctrl_wr && bus_wdata[BIT_RUN];
         if (ctrl_wr) begin
            ctrl.wide     <= bus_wdata[BIT_WIDE];
            ctrl.run      <= bus_wdata[BIT_RUN];
            ctrl.periodic <= bus_wdata[BIT_PERIODIC];
         end
         if (int_wr) int_en <= bus_wdata[BIT_IEN];
      end
   end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             periodic,
   input  logic             wide,
   input  logic             ctrl_wr,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_val,
   output logic             expire,
   output logic             done
);
   localparam int unsigned UP_W = CNT_W - HALF_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_eff;

   // narrow mode sees only the low half of both reload and count
   assign load_eff = wide ? load_val : {{UP_W{1'b0}}, load_val[HALF_W-1:0]};
   assign cnt_val  = wide ? cnt_q    : {{UP_W{1'b0}}, cnt_q[HALF_W-1:0]};
   assign expire   = run && !start && !done && (cnt_val == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (start) begin
         cnt_q <= load_eff;
         done  <= 1'b0;
      end else begin
         if (ctrl_wr) done <= 1'b0;
         if (run && !done) begin
            if (cnt_val == '0) begin
               if (periodic) cnt_q <= load_eff;
               else begin
                  cnt_q <= '0;
                  done  <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_val - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic int_clr,
   input  logic int_en,
   output logic raw,
   output logic masked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw <= 1'b0;
      else if (expire)  raw <= 1'b1;
      else if (int_clr) raw <= 1'b0;
   end

   assign masked = raw && int_en;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned NWORDS = 2;
   localparam int unsigned CNT_W  = NWORDS * DATA_W;

   if (DATA_W <= BIT_WIDE) begin : g_bad_data_w
      $error("evt_timer: DATA_W must exceed the wide-mode bit position");
   end
   if ((1 << ADDR_W) <= OFF_SHD_HI) begin : g_bad_addr_w
      $error("evt_timer: ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] shadow_q;
   ctrl_t            ctrl;
   logic             int_en, start, ctrl_wr, int_wr, int_clr;
   logic             expire, done, raw, masked;

   evt_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .load_val(load_val), .ctrl(ctrl), .int_en(int_en),
      .start(start), .ctrl_wr(ctrl_wr), .int_wr(int_wr), .int_clr(int_clr)
   );

   evt_timer_core #(.HALF_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .run(ctrl.run),
      .periodic(ctrl.periodic), .wide(ctrl.wide), .ctrl_wr(ctrl_wr),
      .load_val(load_val), .cnt_val(cnt_val), .expire(expire), .done(done)
   );

   evt_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .expire(expire), .int_clr(int_clr),
      .int_en(int_en), .raw(raw), .masked(masked)
   );

   assign irq = masked;

   // snapshot of the whole count on a low live read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q <= '0;
      else if (bus_rd && (bus_addr == ADDR_W'(OFF_VAL_LO))) shadow_q <= cnt_val;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            ADDR_W'(OFF_LOAD_LO): bus_rdata = load_val[DATA_W-1:0];
            ADDR_W'(OFF_LOAD_HI): bus_rdata = load_val[CNT_W-1:DATA_W];
            ADDR_W'(OFF_VAL_LO):  bus_rdata = cnt_val[DATA_W-1:0];
            ADDR_W'(OFF_VAL_HI):  bus_rdata = cnt_val[CNT_W-1:DATA_W];
            ADDR_W'(OFF_SHD_LO):  bus_rdata = shadow_q[DATA_W-1:0];
            ADDR_W'(OFF_SHD_HI):  bus_rdata = shadow_q[CNT_W-1:DATA_W];
            ADDR_W'(OFF_CTRL): begin
               bus_rdata[BIT_PERIODIC] = ctrl.periodic;
               bus_rdata[BIT_RUN]      = ctrl.run;
               bus_rdata[BIT_WIDE]     = ctrl.wide;
            end
            ADDR_W'(OFF_INT): begin
               bus_rdata[BIT_IEN] = int_en;
               bus_rdata[BIT_RAW] = raw;
               bus_rdata[BIT_MSK] = masked;
            end
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
   import evt_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_rd,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                wr_clr_bit,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                irq,
   input logic                run,
   input logic                wide,
   input logic                start,
   input logic                done,
   input logic                expire,
   input logic                raw,
   input logic [2*DATA_W-1:0] cnt_val
);
   logic wr_ctrl, wr_int;
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_int  = bus_wr && (bus_addr == ADDR_W'(OFF_INT));

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && !done && cnt_val != '0 && !wr_ctrl) |=> (cnt_val == $past(cnt_val) - 1'b1)); // R3
   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start && !wr_ctrl) |=> $stable(cnt_val)); // R4
   AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw); // R5
   AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |-> (cnt_val == '0)); // R6
   AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFF_VAL_HI) && !wide) |-> (bus_rdata == '0)); // R7
   AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFF_INT)) |-> !bus_rdata[BIT_CLR]); // R8
   AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_int && wr_clr_bit && !expire) |=> !raw); // R9
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_int) |=> irq); // R10
endmodule

bind evt_timer evt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .wr_clr_bit(bus_wdata[3]), .bus_rdata(bus_rdata), .irq(irq), .run(ctrl.run),
   .wide(ctrl.wide), .start(start), .done(done), .expire(expire), .raw(raw),
   .cnt_val(cnt_val)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 5;
   localparam logic [AW-1:0] A_LLO = 5'h00, A_LHI = 5'h04, A_VLO = 5'h08, A_VHI = 5'h0C,
                             A_CTL = 5'h10, A_INT = 5'h14, A_SLO = 5'h18, A_SHI = 5'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;
   int            n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   evt_timer #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   function automatic logic [31:0] exp_cnt(input int L, input bit per, input int n);
      if (per) return 32'(L - ((n - 1) % (L + 1)));
      return (n - 1 <= L) ? 32'(L - (n - 1)) : 32'd0;
   endfunction

   task automatic sweep_case(input int L, input bit per);
      logic [DW-1:0] v;
      wr(A_CTL, 32'h0);
      wr(A_INT, 32'h9);
      wr(A_LLO, 32'(L));
      wr(A_LHI, 32'hA5);
      wr(A_CTL, {30'd0, 1'b1, per});
      tick(1);
      for (int i = 0; i < 2 * L + 5; i++) begin
         check((L + i) % 2 == 0 ? "R10 irq level" : "R5 irq level", {63'd0, irq},
               {63'd0, (i + 1 >= L + 2)});
         rd(A_VLO, v);
         check(per ? "R5 periodic count" : "R6 single-shot count", {32'd0, v},
               {32'd0, exp_cnt(L, per, i + 1)});
      end
      rd(A_VHI, v);
      check("R7 narrow high reads zero", {32'd0, v}, 64'd0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", {63'd0, irq}, 64'd0);
      rd(A_CTL, v); check("R1 ctrl", {32'd0, v}, 64'd0);
      rd(A_INT, v); check("R1 int", {32'd0, v}, 64'd0);
      rd(A_VLO, v); check("R1 count", {32'd0, v}, 64'd0);
      rd(A_SHI, v); check("R1 snapshot", {32'd0, v}, 64'd0);

      // R2 reload words read back
      wr(A_LLO, 32'h1234_5678); wr(A_LHI, 32'h9ABC_DEF0);
      rd(A_LLO, v); check("R2 reload low", {32'd0, v}, 64'h1234_5678);
      rd(A_LHI, v); check("R2 reload high", {32'd0, v}, 64'h9ABC_DEF0);

      // R3 R5 R6 R7 R10 sweep over small reload values and both modes
      for (int L = 0; L <= 5; L++) begin
         sweep_case(L, 1'b1);
         sweep_case(L, 1'b0);
      end

      // R8 raw vs masked status, R6 no refire
      wr(A_CTL, 32'h0); wr(A_INT, 32'h8); wr(A_LLO, 32'd2);
      wr(A_CTL, 32'h2);
      tick(5);
      rd(A_INT, v); check("R8 raw only", {32'd0, v}, 64'h2);
      check("R8 irq masked off", {63'd0, irq}, 64'd0);
      wr(A_INT, 32'h1);
      rd(A_INT, v); check("R8 masked set", {32'd0, v}, 64'h7);
      check("R10 irq on", {63'd0, irq}, 64'd1);
      wr(A_INT, 32'h9);
      rd(A_INT, v); check("R9 cleared", {32'd0, v}, 64'h1);
      check("R9 irq off", {63'd0, irq}, 64'd0);
      tick(5);
      rd(A_INT, v); check("R6 no second expiry", {32'd0, v}, 64'h1);
      rd(A_VLO, v); check("R6 held at zero", {32'd0, v}, 64'd0);

      // R9 clear colliding with expiry (L=3: expiries on edges 5, 9)
      wr(A_CTL, 32'h0); wr(A_INT, 32'h9); wr(A_LLO, 32'd3);
      wr(A_CTL, 32'h3);
      tick(4);
      wr(A_INT, 32'h9);
      check("R9 expiry wins over clear", {63'd0, irq}, 64'd1);
      wr(A_INT, 32'h9);
      check("R9 clear alone", {63'd0, irq}, 64'd0);
      tick(3);
      check("R5 next period", {63'd0, irq}, 64'd1);

      // R4 stop and fresh restart
      wr(A_CTL, 32'h0); wr(A_INT, 32'h9); wr(A_LLO, 32'd10);
      wr(A_CTL, 32'h2);
      tick(3);
      wr(A_CTL, 32'h0);
      rd(A_VLO, v); check("R4 stopped value", {32'd0, v}, 64'd7);
      tick(3);
      rd(A_VLO, v); check("R4 still held", {32'd0, v}, 64'd7);
      wr(A_LLO, 32'd6);
      wr(A_CTL, 32'h2);
      tick(1);
      rd(A_VLO, v); check("R4 fresh start", {32'd0, v}, 64'd6);

      // R7 R11 wide count across the half boundary
      wr(A_CTL, 32'h0); wr(A_INT, 32'h9);
      wr(A_LLO, 32'd2); wr(A_LHI, 32'd1);
      wr(A_CTL, 32'h0001_0002);
      tick(1);
      rd(A_VHI, v); check("R7 wide high", {32'd0, v}, 64'd1);
      rd(A_VLO, v); check("R7 wide low", {32'd0, v}, 64'd1);
      rd(A_SHI, v); check("R11 snapshot high", {32'd0, v}, 64'd1);
      rd(A_SLO, v); check("R11 snapshot low", {32'd0, v}, 64'd1);
      rd(A_VLO, v); check("R7 borrow low", {32'd0, v}, 64'hFFFF_FFFE);
      check("R7 no narrow expiry", {63'd0, irq}, 64'd0);
      rd(A_VHI, v); check("R7 borrow high", {32'd0, v}, 64'd0);
      rd(A_SLO, v); check("R11 snapshot refreshed", {32'd0, v}, 64'hFFFF_FFFE);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule